// File: doc/BRIEF.md
# Shadow-Buffered PWM Generator

This block produces one pulse-width-modulated output from a free-running period counter. Software programs it over a small word-addressed register bus with single-cycle 32-bit writes and registered reads. Period, duty and output polarity are written into shadow copies. The running waveform copies them into its working values only when the counter starts a new period. The output therefore never shows a mixture of old and new settings inside one period.

A hold bit in the control word lets software stage several changes. While it is set, shadowed writes are collected but never transferred. When software clears it, period, duty and polarity all switch together at the next period start. The enable, continuous-mode and hold bits act on the cycle they are written. The counter advances once per clock, with no prescaling.

Top module: `shadow_pwm`

## Requirements
- R1: After synchronous reset the output is low and every register reads zero.
- R2: Registers are selected by `bus_addr[3:2]`: 0 is the live count, 1 the period, 2 the duty and 3 the control word. Reads return data one cycle after `bus_rd_en`. Period and duty read back the last written shadow value. Control bits other than 0, 1, 3, 4 and 6 read as zero.
- R3: The channel runs only while control bit 0 (enable) and bit 1 (continuous) are both set. Otherwise the count is held at 0 and the output drives the inactive level.
- R4: While running, the count steps by one per clock from 0 to period−1 and then wraps to 0.
- R5: While running, the output takes the duty level when the count is below duty and the inactive level otherwise. The output lags the count by one register. A duty of 0 gives a constant inactive level, and a duty at or above the period gives a constant duty level.
- R6: Control bit 3 sets the duty level and control bit 4 sets the inactive level (1 = high, 0 = low).
- R7: With the hold bit clear, new period, duty and polarity values reach the waveform only at a period start, or on any cycle while the channel is stopped.
- R8: While control bit 6 (hold) is set, the working period, duty and polarity do not change, even across period starts. Enable, continuous and hold themselves take effect at once.
- R9: Once the hold bit is cleared, the staged period, duty and polarity take effect together at the first following period start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Write strobe, one word per cycle |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 select the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pwm_out | output | 1 | Registered PWM output |

## Verification
On every cycle the bound assertions check four things: the count stays below the working period, the count steps or wraps correctly, a stopped channel holds the count at zero and drives its inactive level, and the working values stay frozen while held and otherwise change only at a period start. Only the bench scenarios can show that the right waveform appears. Those scenarios check that duty 0 and duty ≥ period give flat outputs, that inverted polarity mirrors the pulse, and that a held period/duty/polarity bundle switches exactly one period boundary after release. For this the bench compares every output cycle against a model built from the requirements.

// File: rtl/shadow_pwm_pkg.sv
package shadow_pwm_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_PERIOD = 2'd1,
    SEL_DUTY   = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic duty_lvl;
    logic idle_lvl;
  } pol_t;

  localparam int CB_EN   = 0;
  localparam int CB_CONT = 1;
  localparam int CB_DUTY = 3;
  localparam int CB_IDLE = 4;
  localparam int CB_HOLD = 6;
endpackage

// File: rtl/shadow_pwm_hold.sv
module shadow_pwm_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/shadow_pwm_regs.sv
module shadow_pwm_regs
  import shadow_pwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] live_cnt,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] sh_period,
  output logic [DATA_W-1:0] sh_duty,
  output pol_t              sh_pol,
  output logic              run,
  output logic              hold
);
  reg_sel_e    sel;
  logic        en_q, cont_q;
  logic [DATA_W-1:0] ctrl_view;

  assign sel = reg_sel_e'(addr[3:2]);
  assign run = en_q & cont_q;

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[CB_EN]   = en_q;
    ctrl_view[CB_CONT] = cont_q;
    ctrl_view[CB_DUTY] = sh_pol.duty_lvl;
    ctrl_view[CB_IDLE] = sh_pol.idle_lvl;
    ctrl_view[CB_HOLD] = hold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_period <= '0;
      sh_duty   <= '0;
      sh_pol    <= '0;
      en_q      <= 1'b0;
      cont_q    <= 1'b0;
      hold      <= 1'b0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_PERIOD: sh_period <= wdata;
        SEL_DUTY:   sh_duty   <= wdata;
        SEL_CTRL: begin
          en_q            <= wdata[CB_EN];
          cont_q          <= wdata[CB_CONT];
          hold            <= wdata[CB_HOLD];
          sh_pol.duty_lvl <= wdata[CB_DUTY];
          sh_pol.idle_lvl <= wdata[CB_IDLE];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      unique case (sel)
        SEL_COUNT:  rdata <= live_cnt;
        SEL_PERIOD: rdata <= sh_period;
        SEL_DUTY:   rdata <= sh_duty;
        SEL_CTRL:   rdata <= ctrl_view;
        default:    rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/shadow_pwm_core.sv
module shadow_pwm_core
  import shadow_pwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              hold,
  input  logic [DATA_W-1:0] sh_period,
  input  logic [DATA_W-1:0] sh_duty,
  input  pol_t              sh_pol,
  output logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] act_period,
  output logic [DATA_W-1:0] act_duty,
  output pol_t              act_pol,
  output logic              pwm_out
);
  localparam int NUM_FIELDS = 2;
  localparam int POL_W      = $bits(pol_t);

  logic              wrap, load;
  logic [DATA_W:0]   cnt_inc;
  logic [DATA_W-1:0] sh_val  [NUM_FIELDS];
  logic [DATA_W-1:0] act_val [NUM_FIELDS];
  logic [POL_W-1:0]  act_pol_bits;

  assign cnt_inc = {1'b0, cnt} + {{DATA_W{1'b0}}, 1'b1};
  assign wrap    = cnt_inc >= {1'b0, act_period};
  assign load    = (!run || wrap) && !hold;

  assign sh_val[0]  = sh_period;
  assign sh_val[1]  = sh_duty;
  assign act_period = act_val[0];
  assign act_duty   = act_val[1];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    shadow_pwm_hold #(.W(DATA_W)) u_field (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .d    (sh_val[g]),
      .q    (act_val[g])
    );
  end

  shadow_pwm_hold #(.W(POL_W)) u_pol (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (sh_pol),
    .q    (act_pol_bits)
  );
  assign act_pol = pol_t'(act_pol_bits);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (!run) cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt_inc[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)                        pwm_out <= 1'b0;
    else if (run && cnt < act_duty) pwm_out <= act_pol.duty_lvl;
    else                            pwm_out <= act_pol.idle_lvl;
  end
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
  import shadow_pwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              pwm_out
);
  logic [DATA_W-1:0] sh_period_w, sh_duty_w, cnt_w, act_period_w, act_duty_w;
  pol_t              sh_pol_w, act_pol_w;
  logic              run_w, hold_w;

  shadow_pwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (bus_wr_en),
    .rd_en     (bus_rd_en),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .live_cnt  (cnt_w),
    .rdata     (bus_rdata),
    .sh_period (sh_period_w),
    .sh_duty   (sh_duty_w),
    .sh_pol    (sh_pol_w),
    .run       (run_w),
    .hold      (hold_w)
  );

  shadow_pwm_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .run        (run_w),
    .hold       (hold_w),
    .sh_period  (sh_period_w),
    .sh_duty    (sh_duty_w),
    .sh_pol     (sh_pol_w),
    .cnt        (cnt_w),
    .act_period (act_period_w),
    .act_duty   (act_duty_w),
    .act_pol    (act_pol_w),
    .pwm_out    (pwm_out)
  );
endmodule

// File: rtl/shadow_pwm_chk.sv
module shadow_pwm_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              hold,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] act_period,
  input logic [DATA_W-1:0] act_duty,
  input logic [1:0]        act_pol,
  input logic              pwm_out
);
  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (run && act_period != '0) |-> (cnt < act_period)); // R4

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && cnt != '0) |-> (cnt == $past(cnt) + 1'b1)); // R4

  AST_STOPPED_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0)); // R3

  AST_STOPPED_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_out == $past(act_pol[0]))); // R3

  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (rst)
    hold |=> ($stable(act_period) && $stable(act_duty) && $stable(act_pol))); // R8

  AST_LOAD_AT_START: assert property (@(posedge clk) disable iff (rst)
    ($past(run) && !($stable(act_period) && $stable(act_duty) && $stable(act_pol)))
      |-> (cnt == '0)); // R7
endmodule

bind shadow_pwm shadow_pwm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .run        (run_w),
  .hold       (hold_w),
  .cnt        (cnt_w),
  .act_period (act_period_w),
  .act_duty   (act_duty_w),
  .act_pol    (act_pol_w),
  .pwm_out    (pwm_out)
);

// File: tb/shadow_pwm_tb_top.sv
module shadow_pwm_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          pwm_out;

  always #10 clk = ~clk;

  shadow_pwm #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .pwm_out(pwm_out)
  );

  typedef struct { logic val; int tag; } exp_t;
  exp_t exp_q[$];
  int   checks = 0, fails = 0, cur_tag = 1;
  bit   done = 1'b0;

  // bench model built from the requirements
  longint m_cnt, m_sp, m_sd, m_ap, m_ad;
  logic   m_en, m_cont, m_hold, m_sduty, m_sidle, m_aduty, m_aidle;

  task automatic model_reset();
    m_cnt = 0; m_sp = 0; m_sd = 0; m_ap = 0; m_ad = 0;
    m_en = 0; m_cont = 0; m_hold = 0;
    m_sduty = 0; m_sidle = 0; m_aduty = 0; m_aidle = 0;
  endtask

  task automatic check(input int tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL R%0d: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle: drive, update model, push expected output
  task automatic cyc(input bit wr, input bit rd, input logic [1:0] sel,
                     input logic [DW-1:0] d, input longint rd_exp, input bit use_model_rd);
    bit     run, wrap, load;
    longint ncnt, rexp;
    exp_t   e;
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = {sel, 2'b00}; wdata = d;
    run  = m_en && m_cont;
    e.val = (run && m_cnt < m_ad) ? m_aduty : m_aidle;
    e.tag = cur_tag;
    exp_q.push_back(e);
    case (sel)
      2'd0: rexp = m_cnt;
      2'd1: rexp = m_sp;
      2'd2: rexp = m_sd;
      default: rexp = longint'({m_hold, 1'b0, m_sidle, m_sduty, 1'b0, m_cont, m_en});
    endcase
    if (!use_model_rd) rexp = rd_exp;
    wrap = (m_cnt + 1) >= m_ap;
    load = (!run || wrap) && !m_hold;
    ncnt = !run ? 0 : (wrap ? 0 : m_cnt + 1);
    if (load) begin m_ap = m_sp; m_ad = m_sd; m_aduty = m_sduty; m_aidle = m_sidle; end
    if (wr) begin
      case (sel)
        2'd1: m_sp = longint'(d);
        2'd2: m_sd = longint'(d);
        2'd3: begin
          m_en = d[0]; m_cont = d[1]; m_sduty = d[3]; m_sidle = d[4]; m_hold = d[6];
        end
        default: ;
      endcase
    end
    m_cnt = ncnt;
    @(posedge clk);
    if (rd) begin
      #3;
      check(2, longint'(rdata), rexp); // R2 read-back
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 2'd0, '0, 0, 1);
  endtask
  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
    cyc(1, 0, sel, d, 0, 1);
  endtask
  task automatic rd(input logic [1:0] sel);
    cyc(0, 1, sel, '0, 0, 1);
  endtask

  // monitor / scoreboard: one popped item per clock
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, longint'(pwm_out), longint'(e.val));
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    cur_tag = 1;
    check(1, longint'(pwm_out), 0);
    cyc(0, 1, 2'd0, '0, 0, 0); cyc(0, 1, 2'd1, '0, 0, 0);
    cyc(0, 1, 2'd2, '0, 0, 0); cyc(0, 1, 2'd3, '0, 0, 0);
    // R3: enable without continuous mode does not run
    cur_tag = 3;
    wr(2'd1, 5); wr(2'd2, 2); wr(2'd3, 32'h0000_0009);
    idle(6); rd(2'd0); rd(2'd3);
    // R4 R5: normal run, period 5 duty 2; unused bits ignored on read (R2)
    cur_tag = 4;
    wr(2'd3, 32'hFFFF_FF8B & 32'h0000_0F0B);
    idle(7); rd(2'd0); idle(3); rd(2'd0); rd(2'd3);
    // R5: duty 0 flat inactive, duty above period flat active
    cur_tag = 5;
    wr(2'd2, 0); idle(12);
    wr(2'd2, 9); idle(12);
    wr(2'd2, 5); idle(8);
    // R6: inverted polarity
    cur_tag = 6;
    wr(2'd2, 2); wr(2'd3, 32'h0000_0013); idle(12);
    // R7: unheld change lands at period start; odd period
    cur_tag = 7;
    wr(2'd1, 3); wr(2'd2, 1); idle(10);
    // R8: hold freezes period, duty and polarity
    cur_tag = 8;
    wr(2'd3, 32'h0000_0053);
    wr(2'd1, 8); wr(2'd2, 6); wr(2'd3, 32'h0000_004B);
    idle(14); rd(2'd1); rd(2'd2);
    // R9: release; new bundle starts at next boundary
    cur_tag = 9;
    wr(2'd3, 32'h0000_000B); idle(20);
    // R3: stop, count held at zero, inactive level from bit 4
    cur_tag = 3;
    wr(2'd3, 32'h0000_0012); idle(5); rd(2'd0);
    wr(2'd3, 32'h0000_0001); idle(5);
    wait (exp_q.size() == 0);
    @(negedge clk);
    summary();
  end
endmodule